// File: doc/BRIEF.md
# Fractional-N Main Divider

This block divides a fast input clock by a programmable integer ratio N with a fractional extension. It emits a single-cycle pulse each time a divide cycle completes. At every such boundary a small accumulator adds a programmed increment, and the accumulator wraps at a selectable modulus of 8 or 5. When the accumulator wraps, the following divide cycle is stretched to N+1. Over one full modulus period the average ratio is therefore N + increment/modulus.

Alongside the divider, the block produces a compensation window that opens at every boundary and stays open for a fixed 128 enabled input cycles. During the window it presents an amplitude code equal to the new accumulator value multiplied by an 8-bit scale code. An external current source can use this code to cancel the phase ripple caused by the fractional stepping.

New settings are captured by a load strobe into a staging copy. They take effect only at the next divide-cycle boundary, so a reprogram never cuts a cycle short.

Top module: `fracn_divider`

## Requirements
- R1: While reset is asserted (active low, asynchronous), `div_pulse_o` is 0 (with enable low), `frac_acc_o` is 0, `comp_en_o` is 0 and `comp_amp_o` is 0; this holds even if reset arrives during an open window. After reset the divide counter is at its terminal count, so the first enabled cycle is a boundary and `div_pulse_o` is 1. The settings in force after reset are ratio 1000, increment 0, modulus 8 and scale 0.
- R2: `div_pulse_o` is high for one enabled cycle per divide cycle. The number of enabled clock edges from one pulse to the next is the active ratio N, or N+1 for a stretched cycle.
- R3: With `mod_sel_i` = 0 the accumulator works modulo 8. At each boundary it becomes (acc + inc) mod 8, and if the sum reached 8 the next divide cycle is N+1 long.
- R4: With `mod_sel_i` = 1 the accumulator works modulo 5. With increment 2 and starting from 0, the values after successive boundaries are 2, 4, 1, 3, 0, and the cycles that follow are N, N, N+1, N, N+1.
- R5: An increment at or above the selected modulus is first reduced by the modulus; for example, increment 7 in modulo 5 behaves as increment 2.
- R6: `load_i` copies ratio, increment, modulus select and scale into a staging copy. The staged values take effect at the next boundary. The divide cycle in progress keeps its old length. Changing the setting inputs without `load_i` has no effect.
- R7: A loaded ratio below 512 is treated as 512.
- R8: `comp_en_o` rises in the cycle after each pulse and stays high for exactly 128 enabled cycles.
- R9: During the window, `comp_amp_o` equals the new accumulator value times the staged scale code, and it is held constant. Outside the window it is 0.
- R10: While `en_i` is low, no pulse is produced and the counter, accumulator and window hold their state. Enabled cycles then resume counting where they stopped.
- R11: The gap between two pulses is never shorter than 512 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable; low freezes the block |
| ratio_i | input | 16 | Integer ratio N (512 to 65535) |
| incr_i | input | 3 | Fractional increment (0 to 7) |
| mod_sel_i | input | 1 | 0: modulo 8, 1: modulo 5 |
| scale_i | input | 8 | Compensation scale code (0 to 255) |
| load_i | input | 1 | Stage the setting inputs for the next boundary |
| div_pulse_o | output | 1 | One-cycle divider output pulse |
| frac_acc_o | output | 3 | Fractional accumulator value |
| comp_en_o | output | 1 | Compensation window active |
| comp_amp_o | output | 11 | Compensation amplitude code |

## Verification
The assertions check, on every cycle, the properties that are local in time. There is no pulse while the block is idle, and no pulse ever lasts more than one cycle. The accumulator and amplitude change only at a boundary, and the window opens only after a pulse. Counters in the checker also bound the window at 128 cycles and keep pulses at least 512 cycles apart.

Only the bench's scenarios can show the arithmetic content. That covers the exact sequence of accumulator values under both moduli and the wrapping of a large increment. It also covers the N versus N+1 lengths, the ratio clamp, the deferral of a reload to the boundary, and the product values on the amplitude output.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int RATIO_W = 16;
    localparam int FRAC_W  = 3;
    localparam int SCALE_W = 8;
    localparam int AMP_W   = FRAC_W + SCALE_W;
    localparam int MOD_WIDE   = 2 ** FRAC_W;
    localparam int MOD_NARROW = 5;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [FRAC_W-1:0]  incr;
        logic               mod_sel;
        logic [SCALE_W-1:0] scale;
    } fracn_cfg_t;
endpackage

// File: rtl/fracn_shadow.sv
module fracn_shadow
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO   = 512,
    parameter int RESET_RATIO = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  fracn_cfg_t cfg_in_i,
    input  logic       bound_i,
    output fracn_cfg_t cfg_eff_o
);
    typedef struct packed {
        fracn_cfg_t staged;
        logic       staged_vld;
        fracn_cfg_t active;
    } shadow_t;

    shadow_t    st_d, st_q;
    fracn_cfg_t cfg_clamped;

    always_comb begin
        cfg_clamped = cfg_in_i;
        if (cfg_in_i.ratio < RATIO_W'(MIN_RATIO)) begin
            cfg_clamped.ratio = RATIO_W'(MIN_RATIO);
        end
        cfg_eff_o = st_q.staged_vld ? st_q.staged : st_q.active;

        st_d = st_q;
        if (bound_i) begin
            st_d.active     = cfg_eff_o;
            st_d.staged_vld = 1'b0;
        end
        if (load_i) begin
            st_d.staged     = cfg_clamped;
            st_d.staged_vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{staged: '0, staged_vld: 1'b0,
                      active: '{ratio: RATIO_W'(RESET_RATIO), incr: '0, mod_sel: 1'b0, scale: '0}};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bound_i,
    input  logic [FRAC_W-1:0] incr_i,
    input  logic              mod_sel_i,
    output logic [FRAC_W-1:0] acc_o,
    output logic [FRAC_W-1:0] acc_next_o,
    output logic              carry_o
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } accum_t;

    accum_t acc_d, acc_q;
    logic [FRAC_W:0] modulus, inc_ext, acc_ext, inc_red, acc_red, sum;

    always_comb begin
        modulus = mod_sel_i ? (FRAC_W+1)'(MOD_NARROW) : (FRAC_W+1)'(MOD_WIDE);
        inc_ext = {1'b0, incr_i};
        acc_ext = {1'b0, acc_q.acc};
        inc_red = (inc_ext >= modulus) ? inc_ext - modulus : inc_ext;
        acc_red = (acc_ext >= modulus) ? acc_ext - modulus : acc_ext;
        sum     = inc_red + acc_red;
        carry_o = (sum >= modulus);
        if (carry_o) begin
            sum = sum - modulus;
        end
        acc_next_o = sum[FRAC_W-1:0];

        acc_d = acc_q;
        if (bound_i) begin
            acc_d.acc = acc_next_o;
        end
        acc_o = acc_q.acc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/fracn_count.sv
module fracn_count
    import fracn_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               carry_i,
    output logic               bound_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } count_t;

    count_t cnt_d, cnt_q;

    always_comb begin
        bound_o = en_i && (cnt_q.cnt == '0);
        cnt_d   = cnt_q;
        if (bound_o) begin
            cnt_d.cnt = ratio_i - RATIO_W'(1) + RATIO_W'(carry_i);
        end else if (en_i) begin
            cnt_d.cnt = cnt_q.cnt - RATIO_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fracn_comp.sv
module fracn_comp
    import fracn_pkg::*;
#(
    parameter int COMP_WIDTH = 128
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               bound_i,
    input  logic [FRAC_W-1:0]  acc_next_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               comp_en_o,
    output logic [AMP_W-1:0]   comp_amp_o
);
    localparam int CW = $clog2(COMP_WIDTH + 1);

    typedef struct packed {
        logic [CW-1:0]    left;
        logic [AMP_W-1:0] amp;
    } comp_t;

    comp_t cp_d, cp_q;

    always_comb begin
        cp_d = cp_q;
        if (bound_i) begin
            cp_d.left = CW'(COMP_WIDTH);
            cp_d.amp  = AMP_W'(acc_next_i) * AMP_W'(scale_i);
        end else if (en_i && (cp_q.left != '0)) begin
            cp_d.left = cp_q.left - CW'(1);
        end
        comp_en_o  = (cp_q.left != '0);
        comp_amp_o = comp_en_o ? cp_q.amp : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cp_q <= '0;
        end else begin
            cp_q <= cp_d;
        end
    end
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO   = 512,
    parameter int RESET_RATIO = 1000,
    parameter int COMP_WIDTH  = 128
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [FRAC_W-1:0]  incr_i,
    input  logic               mod_sel_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               load_i,
    output logic               div_pulse_o,
    output logic [FRAC_W-1:0]  frac_acc_o,
    output logic               comp_en_o,
    output logic [AMP_W-1:0]   comp_amp_o
);
    fracn_cfg_t        cfg_in, cfg_eff;
    logic              bound, carry;
    logic [FRAC_W-1:0] acc_next;

    assign cfg_in = '{ratio: ratio_i, incr: incr_i, mod_sel: mod_sel_i, scale: scale_i};

    fracn_shadow #(.MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)) u_shadow (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .cfg_in_i(cfg_in),
        .bound_i(bound), .cfg_eff_o(cfg_eff)
    );

    fracn_count u_count (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ratio_i(cfg_eff.ratio),
        .carry_i(carry), .bound_o(bound)
    );

    fracn_accum u_accum (
        .clk_i(clk_i), .rst_ni(rst_ni), .bound_i(bound), .incr_i(cfg_eff.incr),
        .mod_sel_i(cfg_eff.mod_sel), .acc_o(frac_acc_o), .acc_next_o(acc_next),
        .carry_o(carry)
    );

    fracn_comp #(.COMP_WIDTH(COMP_WIDTH)) u_comp (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .bound_i(bound),
        .acc_next_i(acc_next), .scale_i(cfg_eff.scale), .comp_en_o(comp_en_o),
        .comp_amp_o(comp_amp_o)
    );

    assign div_pulse_o = bound;
endmodule

// File: rtl/fracn_checker.sv
module fracn_checker
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO  = 512,
    parameter int COMP_WIDTH = 128
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              div_pulse_o,
    input logic [FRAC_W-1:0] frac_acc_o,
    input logic              comp_en_o,
    input logic [AMP_W-1:0]  comp_amp_o
);
    logic [31:0] win_q, gap_q;
    logic        seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q  <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (!comp_en_o)        win_q <= '0;
            else if (en_i)         win_q <= win_q + 32'd1;
            if (en_i) begin
                if (div_pulse_o)   gap_q <= 32'd1;
                else if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 32'd1;
            end
            if (div_pulse_o)       seen_q <= 1'b1;
        end
    end

    p_idle_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !div_pulse_o);
    p_one_cycle_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_pulse_o |=> !div_pulse_o);
    p_acc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !div_pulse_o |=> $stable(frac_acc_o));
    p_window_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(comp_en_o) |-> $past(div_pulse_o));
    p_amp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (comp_en_o && !div_pulse_o) |=> ($stable(comp_amp_o) || !comp_en_o));
    p_window_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_q <= 32'(COMP_WIDTH));
    p_min_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_pulse_o && seen_q) |-> (gap_q >= 32'(MIN_RATIO)));
endmodule

bind fracn_divider fracn_checker #(.MIN_RATIO(MIN_RATIO), .COMP_WIDTH(COMP_WIDTH)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_pulse_o(div_pulse_o),
    .frac_acc_o(frac_acc_o), .comp_en_o(comp_en_o), .comp_amp_o(comp_amp_o)
);

// File: tb/tb_fracn_divider.sv
`timescale 1ns/1ps
module tb_fracn_divider;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic [15:0] ratio_i = '0;
    logic [2:0]  incr_i = '0;
    logic        mod_sel_i = 1'b0;
    logic [7:0]  scale_i = '0;
    logic        load_i = 1'b0;
    logic        div_pulse_o, comp_en_o;
    logic [2:0]  frac_acc_o;
    logic [10:0] comp_amp_o;

    always #4 clk_i = ~clk_i;

    fracn_divider dut (.*);

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        int ratio; int incr; int msel; int scale; int ncyc;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{ratio: 512,  incr: 0, msel: 0, scale: 10,  ncyc: 8},
        '{ratio: 700,  incr: 3, msel: 0, scale: 200, ncyc: 8},
        '{ratio: 1000, incr: 2, msel: 1, scale: 128, ncyc: 5},
        '{ratio: 530,  incr: 7, msel: 1, scale: 255, ncyc: 5},
        '{ratio: 100,  incr: 5, msel: 0, scale: 3,   ncyc: 8},
        '{ratio: 4000, incr: 6, msel: 0, scale: 77,  ncyc: 8}
    };

    // bench model of the settings, built from the requirements
    int m_ratio, m_incr, m_msel, m_scale, m_acc;
    int p_ratio, p_incr, p_msel, p_scale;
    bit p_vld;
    int exp_gap, exp_amp;

    // result of the last span
    int s_gap, s_win, s_acc, s_amp, s_en, s_pulse, s_bad;

    task automatic step();
        @(posedge clk_i);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ratio = 1000; m_incr = 0; m_msel = 0; m_scale = 0; m_acc = 0; p_vld = 0;
    endtask

    task automatic model_stage(input int r, input int i, input int ms, input int sc);
        p_ratio = (r < 512) ? 512 : r; p_incr = i; p_msel = ms; p_scale = sc; p_vld = 1;
    endtask

    task automatic model_boundary();
        int md, inc, a, s, c;
        if (p_vld) begin
            m_ratio = p_ratio; m_incr = p_incr; m_msel = p_msel; m_scale = p_scale; p_vld = 0;
        end
        md  = m_msel ? 5 : 8;
        inc = (m_incr >= md) ? m_incr - md : m_incr;
        a   = (m_acc >= md) ? m_acc - md : m_acc;
        s   = a + inc;
        c   = (s >= md) ? 1 : 0;
        m_acc   = c ? s - md : s;
        exp_gap = m_ratio + c;
        exp_amp = m_acc * m_scale;
    endtask

    // starts at a sample where div_pulse_o is high, ends at the next such sample
    task automatic span(input int load_at, input int pause_at, input int pause_len);
        int a0, c0;
        s_gap = 0; s_win = 0; s_bad = 0;
        do begin
            if (s_gap == pause_at) begin
                en_i = 1'b0;
                a0 = frac_acc_o; c0 = comp_en_o;
                repeat (pause_len) begin
                    step();
                    if (div_pulse_o || frac_acc_o != a0 || comp_en_o != c0) s_bad++;
                end
                en_i = 1'b1;
                #1;
            end
            load_i = (s_gap == load_at);
            if (comp_en_o) s_win++;
            s_gap++;
            step();
            load_i = 1'b0;
            if (s_gap == 1) begin
                s_acc = frac_acc_o; s_amp = comp_amp_o; s_en = comp_en_o; s_pulse = div_pulse_o;
            end
        end while (!div_pulse_o && s_gap < 70000);
    endtask

    function automatic string tag_for(input int incr, input int msel);
        if (msel == 1 && incr >= 5) return "R5";
        return msel ? "R4" : "R3";
    endfunction

    task automatic check_span(input string acc_req);
        chk(s_gap == exp_gap, "R2", "pulse gap", s_gap, exp_gap);
        chk(s_acc == m_acc, acc_req, "accumulator", s_acc, m_acc);
        chk(s_en == 1 && s_win == 128, "R8", "window length", s_win, 128);
        chk(s_amp == exp_amp, "R9", "amplitude", s_amp, exp_amp);
        chk(s_pulse == 0, "R2", "pulse width", s_pulse, 0);
    endtask

    task automatic do_reset();
        en_i = 1'b0; load_i = 1'b0; rst_ni = 1'b0;
        repeat (3) step();
        rst_ni = 1'b1; en_i = 1'b1;
        #1;
        model_reset();
    endtask

    initial begin
        repeat (190000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seq_acc [5] = '{2, 4, 1, 3, 0};
        int seq_gap [5] = '{800, 800, 801, 800, 801};
        // R1: reset state
        repeat (3) step();
        chk(div_pulse_o == 0 && frac_acc_o == 0, "R1", "pulse/acc in reset", frac_acc_o, 0);
        chk(comp_en_o == 0 && comp_amp_o == 0, "R1", "window in reset", comp_amp_o, 0);
        rst_ni = 1'b1; en_i = 1'b1;
        #1;
        model_reset();
        chk(div_pulse_o == 1, "R1", "first enabled cycle is a boundary", div_pulse_o, 1);

        // vector table: staged mid-cycle load, then follow the new setting
        foreach (VECS[v]) begin
            ratio_i = 16'(VECS[v].ratio); incr_i = 3'(VECS[v].incr);
            mod_sel_i = VECS[v].msel[0]; scale_i = 8'(VECS[v].scale);
            model_boundary();
            span(37, -1, 0);
            check_span(tag_for(m_incr, m_msel));
            chk(s_gap == exp_gap, "R6", "old length kept after load", s_gap, exp_gap);
            model_stage(VECS[v].ratio, VECS[v].incr, VECS[v].msel, VECS[v].scale);
            for (int k = 0; k < VECS[v].ncyc; k++) begin
                model_boundary();
                span(-1, -1, 0);
                check_span(tag_for(m_incr, m_msel));
                if (VECS[v].ratio < 512)
                    chk(s_gap >= 512, "R7", "clamped ratio", s_gap, 512);
            end
        end

        // R6: inputs changed without load have no effect
        ratio_i = 16'd3000; incr_i = 3'd1;
        model_boundary();
        span(-1, -1, 0);
        chk(s_gap == exp_gap, "R6", "unloaded inputs ignored", s_gap, exp_gap);

        // R10: enable low freezes the block mid window
        model_boundary();
        span(-1, 20, 300);
        chk(s_bad == 0, "R10", "frozen while disabled", s_bad, 0);
        chk(s_gap == exp_gap, "R10", "enabled cycles resume", s_gap, exp_gap);
        chk(s_win == 128, "R10", "window counts enabled cycles", s_win, 128);

        // R1: reset during an open window
        repeat (3) step();
        chk(comp_en_o == 1, "R8", "window open before reset", comp_en_o, 1);
        en_i = 1'b0; rst_ni = 1'b0;
        #1;
        chk(comp_en_o == 0 && comp_amp_o == 0, "R1", "window closed by reset", comp_en_o, 0);
        chk(frac_acc_o == 0, "R1", "accumulator cleared by reset", frac_acc_o, 0);
        do_reset();

        // R4: 2/5 sequence in modulo 5
        ratio_i = 16'd800; incr_i = 3'd2; mod_sel_i = 1'b1; scale_i = 8'd9;
        model_boundary();
        span(5, -1, 0);
        chk(s_gap == 1000, "R6", "reset ratio before staged load", s_gap, 1000);
        model_stage(800, 2, 1, 9);
        for (int k = 0; k < 5; k++) begin
            model_boundary();
            span(-1, -1, 0);
            chk(s_acc == seq_acc[k], "R4", "2/5 accumulator sequence", s_acc, seq_acc[k]);
            chk(s_gap == seq_gap[k], "R4", "2/5 cycle lengths", s_gap, seq_gap[k]);
            chk(s_amp == seq_acc[k] * 9, "R9", "2/5 amplitude", s_amp, seq_acc[k] * 9);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule